// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Sequencer

This block drives an active-low system reset line from three sources: the initial power-up, a low-supply indication from an external comparator, and the expiry of a watchdog timer. The supply flag arrives already synchronous. The watchdog is restarted by falling edges on a chip-select style input, which is first passed through a synchronizer and an edge detector. A two-bit select chooses one of three watchdog periods or switches the watchdog off.

Every delay is counted in ticks of a prescaler strobe, nominally one per millisecond. The default parameters give an 800-tick supply hold, watchdog periods of 1400, 600 and 400 ticks, and watchdog reset pulses of 200 or 400 ticks. A testbench can scale all of these down. Two one-cycle cause strobes, one for the watchdog and one for the supply, mark the start of each reset so that a flag register elsewhere can record why the system was reset.

The supply always takes precedence. A low-supply indication during a watchdog reset pulse turns that pulse into a supply hold, and the hold is then released only by the supply rule.

Top module: `sup_reset_seq`

## Requirements
- R1: `rst_n_o` is active low. It is low while `por_n_i` is low. After `por_n_i` rises with `lowv_i` low, it stays low for exactly `HOLD_TICKS` ticks and then goes high.
- R2: When `lowv_i` is high while the reset is released, `rst_n_o` goes low on the next clock. `cause_pwr_o` pulses for one cycle in that same cycle.
- R3: `rst_n_o` stays low while `lowv_i` is high. It is released `HOLD_TICKS` ticks after `lowv_i` clears, and any assertion of `lowv_i` during the hold restarts the count.
- R4: The watchdog period is set by `wd_sel_i`: 2'b00 gives `WD_TICKS_0`, 2'b01 gives `WD_TICKS_1` and 2'b10 gives `WD_TICKS_2`. With a tick every clock and no kick, `rst_n_o` falls on the (period+1)-th clock after it was released.
- R5: When `wd_sel_i` is 2'b11 the watchdog never expires.
- R6: Only a high-to-low transition of the synchronized `wdi_i` restarts the watchdog. A rising edge has no effect, and holding the input steadily high or steadily low leads to a timeout.
- R7: A watchdog reset holds `rst_n_o` low for `PULSE_SHORT` ticks when the select is 2'b00 or 2'b01, and for `PULSE_LONG` ticks when it is 2'b10. The select is sampled at the moment of expiry.
- R8: `cause_wd_o` pulses for one cycle in the cycle that a watchdog reset begins. The two cause strobes are never high together.
- R9: The watchdog count is held at zero while the reset is active, so each released period starts from a full count.
- R10: If `lowv_i` rises during a watchdog reset pulse, the block moves to the supply hold, pulses `cause_pwr_o`, and is released only by the R3 rule.
- R11: No cause strobe fires at power-up or when a reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| lowv_i | input | 1 | Synchronous low-supply flag from the comparator |
| wdi_i | input | 1 | Chip-select / watchdog kick input, asynchronous |
| wd_sel_i | input | 2 | Watchdog period select (2'b11 = off) |
| tick_i | input | 1 | One-cycle timebase strobe from a prescaler |
| rst_n_o | output | 1 | System reset, active low |
| cause_wd_o | output | 1 | One-cycle strobe: a watchdog reset began |
| cause_pwr_o | output | 1 | One-cycle strobe: a supply reset began |

## Verification
The case that is hardest to reach from the ports is a supply drop that lands inside a watchdog reset pulse. Reaching it requires a watchdog expiry first, and the bench then has to raise `lowv_i` in the short window before the pulse ends. The bench gets there by letting the watchdog expire on purpose with the input held still. It detects the first low sample of `rst_n_o` together with `cause_wd_o`, raises the flag on the very next cycle, and then confirms that the release timing follows the supply hold and not the shorter pulse. A second hard case is proving that a rising edge on the kick input does nothing. The bench raises the input a fixed number of cycles into a period and checks that the total released time still equals the full period plus one.

// File: rtl/sup_pkg.sv
package sup_pkg;

   typedef enum logic [1:0] {
      ST_HOLD  = 2'd0,
      ST_RUN   = 2'd1,
      ST_WDRST = 2'd2
   } sup_state_e;

   localparam logic [1:0] SEL_P_LONG  = 2'b00;
   localparam logic [1:0] SEL_P_MID   = 2'b01;
   localparam logic [1:0] SEL_P_SHORT = 2'b10;
   localparam logic [1:0] SEL_OFF     = 2'b11;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sup_wdi_sync.sv
module sup_wdi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic wdi_i,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sup_wdi_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge por_n_i) begin
            if (!por_n_i) chain_q[0] <= 1'b1;
            else          chain_q[0] <= wdi_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge por_n_i) begin
            if (!por_n_i) chain_q[i] <= 1'b1;
            else          chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

   // a falling edge is reported for a single cycle only
   p_fall_single_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      fall_o |=> !fall_o);

endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
   import sup_pkg::*;
#(
   parameter int WD_TICKS_0 = 1400,
   parameter int WD_TICKS_1 = 600,
   parameter int WD_TICKS_2 = 400,
   parameter int CNT_W      = 11
) (
   input  logic       clk_i,
   input  logic       por_n_i,
   input  logic       run_i,
   input  logic       kick_i,
   input  logic       tick_i,
   input  logic [1:0] sel_i,
   output logic       expire_o
);

   if (WD_TICKS_0 < 2 || WD_TICKS_1 < 2 || WD_TICKS_2 < 2) begin : g_bad_period
      $error("sup_wd_timer: every watchdog period must be at least 2 ticks");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_m1;
   logic             enabled;
   logic             expire_q;

   always_comb begin
      unique case (sel_i)
         SEL_P_LONG:  last_m1 = CNT_W'(WD_TICKS_0 - 1);
         SEL_P_MID:   last_m1 = CNT_W'(WD_TICKS_1 - 1);
         SEL_P_SHORT: last_m1 = CNT_W'(WD_TICKS_2 - 1);
         default:     last_m1 = '1;
      endcase
   end

   assign enabled = (sel_i != SEL_OFF);

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         cnt_q    <= '0;
         expire_q <= 1'b0;
      end else begin
         expire_q <= 1'b0;
         if (!run_i || kick_i || !enabled) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            if (cnt_q >= last_m1) begin
               cnt_q    <= '0;
               expire_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign expire_o = expire_q;

   // count held clear while reset is active
   p_clear_in_reset_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !run_i |=> (cnt_q == '0));
   // a kick restarts the period
   p_kick_restarts_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      kick_i |=> (cnt_q == '0) && !expire_o);
   // disabled select never produces an expiry
   p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (sel_i == SEL_OFF) |=> !expire_o);
   p_expire_single_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
      expire_o |=> !expire_o);

endmodule

// File: rtl/sup_rst_fsm.sv
module sup_rst_fsm
   import sup_pkg::*;
#(
   parameter int HOLD_TICKS  = 800,
   parameter int PULSE_SHORT = 200,
   parameter int PULSE_LONG  = 400,
   parameter int CNT_W       = 10
) (
   input  logic       clk_i,
   input  logic       por_n_i,
   input  logic       lowv_i,
   input  logic       tick_i,
   input  logic       expire_i,
   input  logic [1:0] sel_i,
   output logic       run_o,
   output logic       cause_wd_o,
   output logic       cause_pwr_o
);

   if (HOLD_TICKS < 1 || PULSE_SHORT < 1 || PULSE_LONG < 1) begin : g_bad_len
      $error("sup_rst_fsm: hold and pulse lengths must be at least 1 tick");
   end

   localparam logic [CNT_W-1:0] HOLD_M1  = CNT_W'(HOLD_TICKS - 1);
   localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(PULSE_SHORT - 1);
   localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(PULSE_LONG - 1);

   sup_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] plen_m1_q;
   logic             cwd_q;
   logic             cpwr_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         state_q   <= ST_HOLD;
         cnt_q     <= '0;
         plen_m1_q <= '0;
         cwd_q     <= 1'b0;
         cpwr_q    <= 1'b0;
      end else begin
         cwd_q  <= 1'b0;
         cpwr_q <= 1'b0;
         unique case (state_q)
            ST_HOLD: begin
               if (lowv_i) begin
                  cnt_q <= '0;
               end else if (tick_i) begin
                  if (cnt_q == HOLD_M1) begin
                     cnt_q   <= '0;
                     state_q <= ST_RUN;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            ST_RUN: begin
               cnt_q <= '0;
               if (lowv_i) begin
                  state_q <= ST_HOLD;
                  cpwr_q  <= 1'b1;
               end else if (expire_i) begin
                  state_q   <= ST_WDRST;
                  cwd_q     <= 1'b1;
                  plen_m1_q <= (sel_i == SEL_P_SHORT) ? LONG_M1 : SHORT_M1;
               end
            end
            ST_WDRST: begin
               if (lowv_i) begin
                  state_q <= ST_HOLD;
                  cnt_q   <= '0;
                  cpwr_q  <= 1'b1;
               end else if (tick_i) begin
                  if (cnt_q == plen_m1_q) begin
                     cnt_q   <= '0;
                     state_q <= ST_RUN;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            default: begin
               state_q <= ST_HOLD;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign run_o       = (state_q == ST_RUN);
   assign cause_wd_o  = cwd_q;
   assign cause_pwr_o = cpwr_q;

   // supply flag always forces reset on the following cycle
   p_lowv_holds_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
      lowv_i |=> !run_o);
   p_run_drop_r2: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (run_o && lowv_i) |=> cause_pwr_o);
   // supply takes over a running watchdog pulse
   p_pulse_override_r10: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (state_q == ST_WDRST && lowv_i) |=> (state_q == ST_HOLD) && cause_pwr_o);
   p_expiry_starts_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (run_o && expire_i && !lowv_i) |=> cause_wd_o && !run_o);

endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
   import sup_pkg::*;
#(
   parameter int HOLD_TICKS  = 800,
   parameter int WD_TICKS_0  = 1400,
   parameter int WD_TICKS_1  = 600,
   parameter int WD_TICKS_2  = 400,
   parameter int PULSE_SHORT = 200,
   parameter int PULSE_LONG  = 400,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       por_n_i,
   input  logic       lowv_i,
   input  logic       wdi_i,
   input  logic [1:0] wd_sel_i,
   input  logic       tick_i,
   output logic       rst_n_o,
   output logic       cause_wd_o,
   output logic       cause_pwr_o
);

   localparam int WD_MAX  = imax(imax(WD_TICKS_0, WD_TICKS_1), WD_TICKS_2);
   localparam int WD_W    = $clog2(WD_MAX + 1);
   localparam int SEQ_MAX = imax(HOLD_TICKS, imax(PULSE_SHORT, PULSE_LONG));
   localparam int SEQ_W   = $clog2(SEQ_MAX + 1);

   logic kick;
   logic expire;
   logic run;

   sup_wdi_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .wdi_i   (wdi_i),
      .fall_o  (kick)
   );

   sup_wd_timer #(
      .WD_TICKS_0 (WD_TICKS_0),
      .WD_TICKS_1 (WD_TICKS_1),
      .WD_TICKS_2 (WD_TICKS_2),
      .CNT_W      (WD_W)
   ) u_wd (
      .clk_i    (clk_i),
      .por_n_i  (por_n_i),
      .run_i    (run),
      .kick_i   (kick),
      .tick_i   (tick_i),
      .sel_i    (wd_sel_i),
      .expire_o (expire)
   );

   sup_rst_fsm #(
      .HOLD_TICKS  (HOLD_TICKS),
      .PULSE_SHORT (PULSE_SHORT),
      .PULSE_LONG  (PULSE_LONG),
      .CNT_W       (SEQ_W)
   ) u_fsm (
      .clk_i       (clk_i),
      .por_n_i     (por_n_i),
      .lowv_i      (lowv_i),
      .tick_i      (tick_i),
      .expire_i    (expire),
      .sel_i       (wd_sel_i),
      .run_o       (run),
      .cause_wd_o  (cause_wd_o),
      .cause_pwr_o (cause_pwr_o)
   );

   assign rst_n_o = run;

   p_causes_excl_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !(cause_wd_o && cause_pwr_o));
   p_wd_cause_edge_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
      cause_wd_o |-> $fell(rst_n_o));
   p_release_quiet_r11: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(rst_n_o) |-> !cause_wd_o && !cause_pwr_o);

endmodule

// File: tb/sup_reset_seq_tb.sv
`timescale 1ns/1ps
module sup_reset_seq_tb_top;

   localparam int HOLD = 8;
   localparam int P0   = 14;
   localparam int P1   = 6;
   localparam int P2   = 4;
   localparam int PS   = 2;
   localparam int PL   = 4;

   // {select, expected released cycles, expected pulse cycles}
   localparam int NVEC = 4;
   localparam logic [23:0] VEC [NVEC] = '{
      {8'd0, 8'(P0 + 1), 8'(PS)},
      {8'd1, 8'(P1 + 1), 8'(PS)},
      {8'd2, 8'(P2 + 1), 8'(PL)},
      {8'd1, 8'(P1 + 1), 8'(PS)}
   };

   logic       clk = 1'b0;
   logic       por_n;
   logic       lowv;
   logic       wdi;
   logic [1:0] sel;
   logic       tick;
   logic       rst_n;
   logic       cwd;
   logic       cpwr;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   sup_reset_seq #(
      .HOLD_TICKS  (HOLD),
      .WD_TICKS_0  (P0),
      .WD_TICKS_1  (P1),
      .WD_TICKS_2  (P2),
      .PULSE_SHORT (PS),
      .PULSE_LONG  (PL),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk_i       (clk),
      .por_n_i     (por_n),
      .lowv_i      (lowv),
      .wdi_i       (wdi),
      .wd_sel_i    (sel),
      .tick_i      (tick),
      .rst_n_o     (rst_n),
      .cause_wd_o  (cwd),
      .cause_pwr_o (cpwr)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic count_lvl(input logic lvl, output int n);
      n = 0;
      while (rst_n === lvl && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      int lows;
      por_n = 1'b0; lowv = 1'b0; wdi = 1'b1; sel = 2'b11; tick = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset state rst_n", int'(rst_n), 0);
      chk("R11 reset state causes", int'({cwd, cpwr}), 0);

      // power-up hold
      por_n = 1'b1;
      count_lvl(1'b0, n);
      chk("R1 power-up hold length", n, HOLD);
      chk("R11 no cause at release", int'({cwd, cpwr}), 0);

      // disabled watchdog
      lows = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (!rst_n) lows++;
      end
      chk("R5 disabled watchdog never fires", lows, 0);

      // regular kicks keep reset released
      sel = 2'b10;
      lows = 0;
      for (int i = 0; i < 40; i++) begin
         wdi = ~wdi;
         @(negedge clk);
         if (!rst_n) lows++;
      end
      chk("R6 falling edges keep watchdog alive", lows, 0);
      wdi = 1'b0;
      count_lvl(1'b1, n);
      chk("R6 held-low input times out", int'(n >= P2 && n <= P2 + 6), 1);
      chk("R8 watchdog cause at held-low timeout", int'({cwd, cpwr}), 2);
      count_lvl(1'b0, n);
      chk("R7 long pulse for select 10", n, PL);

      // rising edge alone must not restart the period
      @(negedge clk);
      @(negedge clk);
      wdi = 1'b1;
      count_lvl(1'b1, n);
      chk("R6 rising edge ignored", n + 2, P2 + 1);

      // vector walk: steady-high input, period and pulse per select
      sel = VEC[0][17:16];
      count_lvl(1'b0, n);
      for (int v = 0; v < NVEC; v++) begin
         count_lvl(1'b1, n);
         chk("R4 R9 released cycles for select", n, int'(VEC[v][15:8]));
         chk("R8 watchdog cause strobe", int'({cwd, cpwr}), 2);
         if (v + 1 < NVEC) sel = VEC[v+1][17:16];
         count_lvl(1'b0, n);
         chk("R7 pulse length for select", n, int'(VEC[v][7:0]));
      end

      // brownout while released
      lowv = 1'b1;
      @(negedge clk);
      chk("R2 supply cause and reset", int'({rst_n, cwd, cpwr}), 1);
      @(negedge clk);
      chk("R8 cause strobe lasts one cycle", int'({cwd, cpwr}), 0);
      repeat (4) @(negedge clk);
      chk("R3 reset held while flag high", int'(rst_n), 0);
      lowv = 1'b0;
      count_lvl(1'b0, n);
      chk("R3 release after supply hold", n, HOLD);

      // flag blip during the hold restarts the count
      lowv = 1'b1;
      @(negedge clk);
      lowv = 1'b0;
      repeat (4) @(negedge clk);
      lowv = 1'b1;
      @(negedge clk);
      lowv = 1'b0;
      count_lvl(1'b0, n);
      chk("R3 hold restarts on flag", n, HOLD);

      // supply drop inside a watchdog pulse
      sel = 2'b10;
      count_lvl(1'b1, n);
      chk("R8 watchdog pulse begins", int'({cwd, cpwr}), 2);
      lowv = 1'b1;
      @(negedge clk);
      chk("R10 supply cause inside pulse", int'({cwd, cpwr}), 1);
      repeat (3) @(negedge clk);
      lowv = 1'b0;
      count_lvl(1'b0, n);
      chk("R10 supply hold replaces pulse", n, HOLD);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule